// File: doc/BRIEF.md
# Program memory bank translator

This block sits between a CPU and its program storage. It takes a CPU address in the upper part of the address map and produces a physical byte address, together with a flag that says whether that address points into the program ROM or into the work RAM. The translation depends on five 8-bit bank registers and a 2-bit layout mode. The CPU loads all six values through a plain write port that has an address, data and a write strobe.

The 0x6000–0x7FFF window always goes to one 8 KB page of RAM. The 0x8000–0xFFFF range goes to ROM through one of four layouts:
- one 32 KB bank;
- two 16 KB banks;
- one 16 KB bank followed by two 8 KB banks;
- four 8 KB banks.

In the wider layouts, the bank number comes from a shifted field of the same register. The ROM size is a power-of-two parameter, so the ROM offset wraps by keeping its low bits. Each lookup request gives a registered result one clock later.

Top module: `prg_bank_xlate`

## Requirements
- R1: A write to 0x5100 loads the layout mode from data bits [1:0] and ignores the other data bits. Mode encoding: 0 is 32K, 1 is 16K+16K, 2 is 16K+8K+8K, 3 is 4×8K. A lookup issued in the cycle after the write uses the new mode.
- R2: A write to 0x5113+i (i = 0..4) loads bank register i with all 8 data bits. A lookup issued in the cycle after the write uses the new value.
- R3: An address in 0x6000–0x7FFF selects RAM. The physical address is {register 0 bits [2:0], address bits [12:0]}.
- R4: Mode 0: the whole 0x8000–0xFFFF range maps to one 32 KB bank. The bank number is register 4 bits [6:2], and the ROM offset is bank×32768 + address bits [14:0].
- R5: Mode 1: 0x8000–0xBFFF uses 16 KB bank register 2 bits [6:1], and 0xC000–0xFFFF uses register 4 bits [6:1]. The offset is bank×16384 + address bits [13:0].
- R6: Mode 2: 0x8000–0xBFFF uses 16 KB bank register 2 bits [6:1]. 0xC000–0xDFFF uses 8 KB bank register 3 bits [6:0], and 0xE000–0xFFFF uses 8 KB bank register 4 bits [6:0].
- R7: Mode 3: the four 8 KB quarters of 0x8000–0xFFFF, in ascending order, use registers 1, 2, 3, 4 bits [6:0]. The offset is bank×8192 + address bits [12:0].
- R8: Every ROM offset wraps modulo the ROM size (ROM_BYTES), so bank numbers beyond the ROM fold back into it.
- R9: After reset the outputs are idle and the mode is 3. Registers 1..4 hold N−4, N−3, N−2, N−1 masked to 7 bits, where N = ROM_BYTES/8192. Register 0 holds 0.
- R10: An address below 0x6000 selects neither ROM nor RAM and returns physical address 0. ROM select and RAM select are never both high.
- R11: A write to any address other than 0x5100 and 0x5113–0x5117 changes neither the mode nor any bank register. With the write strobe low, no register changes.
- R12: Each cycle with lookup_valid high gives exactly one result, with out_valid high one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_addr | input | 16 | CPU address to translate |
| out_valid | output | 1 | Result valid |
| out_rom_sel | output | 1 | Result points into ROM |
| out_ram_sel | output | 1 | Result points into RAM |
| out_phys_addr | output | ROM_AW (17) | Physical byte address |

## Verification
The assertions assume that the write port and the lookup port are driven with known values while reset is low. They also assume that the register-hold check is only meaningful when the write strobe is a clean single-cycle pulse. The stimulus raises the strobe for exactly one cycle per write and always drives both the address and the data fully. It changes lookup addresses only on the falling edge, so each registered result comes from one stable request. The write addresses used to probe the ignored cases are the immediate neighbours of the decoded range.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  typedef enum logic [1:0] {
    LAYOUT_32K     = 2'd0,
    LAYOUT_16_16   = 2'd1,
    LAYOUT_16_8_8  = 2'd2,
    LAYOUT_8X4     = 2'd3
  } layout_t;

  localparam int NUM_BANK_REGS = 5;
  localparam int PAGE_BITS     = 13;          // 8 KB page offset
  localparam logic [15:0] MODE_ADDR = 16'h5100;
  localparam logic [15:0] REG_BASE  = 16'h5113;
  localparam int FULL_ROM_W    = 7 + PAGE_BITS; // widest 8 KB bank times page
endpackage

// File: rtl/prg_bank_regfile.sv
module prg_bank_regfile
  import prg_bank_pkg::*;
#(
  parameter int BANK_COUNT = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [15:0]                   wr_addr,
  input  logic [7:0]                    wr_data,
  output layout_t                       mode,
  output logic [NUM_BANK_REGS-1:0][7:0] bank_regs
);
  layout_t                       mode_q;
  logic [NUM_BANK_REGS-1:0][7:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= LAYOUT_8X4;
    else if (wr_en && wr_addr == MODE_ADDR) mode_q <= layout_t'(wr_data[1:0]);
  end

  for (genvar gi = 0; gi < NUM_BANK_REGS; gi++) begin : g_reg
    localparam logic [7:0] RST_VAL = (gi == 0) ? 8'h00
      : 8'((BANK_COUNT - NUM_BANK_REGS + gi) & 'h7F);
    localparam logic [15:0] MY_ADDR = 16'(REG_BASE + gi);
    always_ff @(posedge clk) begin
      if (rst) bank_q[gi] <= RST_VAL;
      else if (wr_en && wr_addr == MY_ADDR) bank_q[gi] <= wr_data;
    end
  end

  assign mode      = mode_q;
  assign bank_regs = bank_q;

  // R1: mode follows low data bits of a mode write
  p_mode_load_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == MODE_ADDR) |=> (mode_q == $past(wr_data[1:0])));
  // R2: first bank register captures full data byte
  p_reg0_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_BASE) |=> (bank_q[0] == $past(wr_data)));
  // R11: no strobe, no change
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(bank_q) && $stable(mode_q)));
endmodule

// File: rtl/prg_bank_rom_window.sv
module prg_bank_rom_window
  import prg_bank_pkg::*;
#(
  parameter int ROM_AW = 17
) (
  input  layout_t                       mode,
  input  logic [NUM_BANK_REGS-1:0][7:0] bank_regs,
  input  logic [14:0]                   cpu_off,
  output logic [ROM_AW-1:0]             rom_addr
);
  logic [6:0]            bank8;
  logic [FULL_ROM_W-1:0] full_off;
  logic                  unused_bits;

  always_comb begin
    bank8 = '0;
    unique case (mode)
      LAYOUT_32K:   bank8 = {bank_regs[4][6:2], cpu_off[14:13]};
      LAYOUT_16_16: bank8 = cpu_off[14] ? {bank_regs[4][6:1], cpu_off[13]}
                                        : {bank_regs[2][6:1], cpu_off[13]};
      LAYOUT_16_8_8: begin
        if (!cpu_off[14])     bank8 = {bank_regs[2][6:1], cpu_off[13]};
        else if (!cpu_off[13]) bank8 = bank_regs[3][6:0];
        else                   bank8 = bank_regs[4][6:0];
      end
      default:      bank8 = bank_regs[1 + cpu_off[14:13]][6:0];
    endcase
    full_off = {bank8, cpu_off[PAGE_BITS-1:0]};
  end

  // power-of-two ROM: wrap by keeping low bits
  assign rom_addr = ROM_AW'(full_off);

  assign unused_bits = ^{bank_regs[0], bank_regs[1][7], bank_regs[2][7],
                         bank_regs[2][0], bank_regs[3][7], bank_regs[4][7]};
endmodule

// File: rtl/prg_bank_ram_window.sv
module prg_bank_ram_window
  import prg_bank_pkg::*;
#(
  parameter int RAM_PAGE_BITS = 3
) (
  input  logic [7:0]                          page_reg,
  input  logic [PAGE_BITS-1:0]                cpu_off,
  output logic [RAM_PAGE_BITS+PAGE_BITS-1:0]  ram_addr
);
  logic unused_bits;
  assign ram_addr    = {page_reg[RAM_PAGE_BITS-1:0], cpu_off};
  assign unused_bits = ^page_reg[7:RAM_PAGE_BITS];
endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
  import prg_bank_pkg::*;
#(
  parameter int ROM_BYTES     = 131072,
  parameter int RAM_PAGE_BITS = 3,
  localparam int ROM_AW       = $clog2(ROM_BYTES),
  localparam int BANK_COUNT   = ROM_BYTES / 8192,
  localparam int RAM_AW       = RAM_PAGE_BITS + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              lookup_valid,
  input  logic [15:0]       lookup_addr,
  output logic              out_valid,
  output logic              out_rom_sel,
  output logic              out_ram_sel,
  output logic [ROM_AW-1:0] out_phys_addr
);
  layout_t                       mode;
  logic [NUM_BANK_REGS-1:0][7:0] bank_regs;
  logic [ROM_AW-1:0]             rom_addr;
  logic [RAM_AW-1:0]             ram_addr;
  logic                          hit_rom, hit_ram;

  prg_bank_regfile #(.BANK_COUNT(BANK_COUNT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode), .bank_regs(bank_regs));

  prg_bank_rom_window #(.ROM_AW(ROM_AW)) u_rom (
    .mode(mode), .bank_regs(bank_regs), .cpu_off(lookup_addr[14:0]),
    .rom_addr(rom_addr));

  prg_bank_ram_window #(.RAM_PAGE_BITS(RAM_PAGE_BITS)) u_ram (
    .page_reg(bank_regs[0]), .cpu_off(lookup_addr[PAGE_BITS-1:0]),
    .ram_addr(ram_addr));

  assign hit_rom = lookup_addr[15];
  assign hit_ram = (lookup_addr[15:13] == 3'b011);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_rom_sel   <= 1'b0;
      out_ram_sel   <= 1'b0;
      out_phys_addr <= '0;
    end else begin
      out_valid     <= lookup_valid;
      out_rom_sel   <= lookup_valid && hit_rom;
      out_ram_sel   <= lookup_valid && hit_ram;
      if (lookup_valid && hit_rom)      out_phys_addr <= rom_addr;
      else if (lookup_valid && hit_ram) out_phys_addr <= ROM_AW'(ram_addr);
      else                              out_phys_addr <= '0;
    end
  end

  // R10: selects are exclusive
  p_sel_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_rom_sel, out_ram_sel}));
  // R10: low addresses select nothing
  p_below_window_r10: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && lookup_addr < 16'h6000) |=> (!out_rom_sel && !out_ram_sel));
  // R12: one result per request, one clock later
  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> out_valid);
  // R3: page offset passes through unchanged
  p_page_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && lookup_addr[15:13] != 3'b000 && lookup_addr[15:13] != 3'b001
     && lookup_addr[15:13] != 3'b010)
    |=> (out_phys_addr[PAGE_BITS-1:0] == $past(lookup_addr[PAGE_BITS-1:0])));
endmodule

// File: tb/prg_bank_xlate_bench.sv
module prg_bank_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_BYTES  = 131072;
  localparam int ROM_AW     = 17;
  localparam int NBANK      = ROM_BYTES / 8192;

  typedef struct packed {
    logic              rom;
    logic              ram;
    logic [ROM_AW-1:0] addr;
  } exp_t;

  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [15:0] wr_addr = '0; logic [7:0] wr_data = '0;
  logic lookup_valid = 0; logic [15:0] lookup_addr = '0;
  logic out_valid, out_rom_sel, out_ram_sel;
  logic [ROM_AW-1:0] out_phys_addr;

  int tests = 0, fails = 0;
  exp_t  expq[$];
  string tagq[$];
  int    sh_mode;
  int    sh_reg[5];

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_xlate u_prg_bank_xlate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .out_valid(out_valid), .out_rom_sel(out_rom_sel), .out_ram_sel(out_ram_sel),
    .out_phys_addr(out_phys_addr));

  function automatic exp_t model(input int a);
    exp_t e; int bank8; int off;
    e = '0;
    if (a >= 'h8000) begin
      off = a & 'h1FFF;
      case (sh_mode)
        0: bank8 = ((sh_reg[4] >> 2) & 'h1F) * 4 + ((a >> 13) & 3);
        1: bank8 = (((a >> 14) & 1) ? ((sh_reg[4] >> 1) & 'h3F)
                                      : ((sh_reg[2] >> 1) & 'h3F)) * 2 + ((a >> 13) & 1);
        2: if (((a >> 14) & 1) == 0) bank8 = ((sh_reg[2] >> 1) & 'h3F) * 2 + ((a >> 13) & 1);
           else if (((a >> 13) & 1) == 0) bank8 = sh_reg[3] & 'h7F;
           else bank8 = sh_reg[4] & 'h7F;
        default: bank8 = sh_reg[1 + ((a >> 13) & 3)] & 'h7F;
      endcase
      e.rom = 1; e.addr = ROM_AW'((bank8 * 8192 + off) % ROM_BYTES);
    end else if (a >= 'h6000) begin
      e.ram = 1; e.addr = ROM_AW'((sh_reg[0] & 7) * 8192 + (a & 'h1FFF));
    end
    return e;
  endfunction

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 16'h5100) sh_mode = d & 3;
    else if (a >= 16'h5113 && a <= 16'h5117) sh_reg[a - 16'h5113] = d;
  endtask

  task automatic lookup(input int a, input string tag);
    @(negedge clk);
    lookup_valid = 1; lookup_addr = 16'(a);
    expq.push_back(model(a)); tagq.push_back(tag);
    @(negedge clk);
    lookup_valid = 0;
  endtask

  // monitor: pop and compare as results appear
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && out_valid) begin
        tests++;
        if (expq.size() == 0) begin
          fails++; $display("FAIL R12 unexpected result addr=%h", out_phys_addr);
        end else begin
          exp_t e; string t;
          e = expq.pop_front(); t = tagq.pop_front();
          if ({out_rom_sel, out_ram_sel, out_phys_addr} !== e) begin
            fails++;
            $display("FAIL %s got rom=%0b ram=%0b addr=%h exp rom=%0b ram=%0b addr=%h",
                     t, out_rom_sel, out_ram_sel, out_phys_addr, e.rom, e.ram, e.addr);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    sh_mode = 3; sh_reg[0] = 0;
    for (int i = 1; i < 5; i++) sh_reg[i] = (NBANK - 5 + i) & 'h7F;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tests++; // R9: idle outputs after reset
    if (out_valid !== 0 || out_rom_sel !== 0 || out_ram_sel !== 0 || out_phys_addr !== '0) begin
      fails++; $display("FAIL R9 reset outputs got v=%0b addr=%h exp 0", out_valid, out_phys_addr);
    end
    // R9 default mode 3 with last four banks
    lookup('h8000, "R9"); lookup('hA001, "R9"); lookup('hC0F0, "R9"); lookup('hFFFF, "R9");
    // R3 RAM window; R2 register 0 load
    lookup('h6010, "R3");
    reg_write(16'h5113, 8'hFD); lookup('h6010, "R3"); lookup('h7FFF, "R2");
    // R10 below window
    lookup('h5FFF, "R10"); lookup('h0000, "R10");
    // R7 four quarters, R8 wrap of 0x22
    reg_write(16'h5114, 8'h03); reg_write(16'h5115, 8'h22);
    reg_write(16'h5116, 8'h07); reg_write(16'h5117, 8'h09);
    lookup('h8123, "R7"); lookup('hA456, "R8"); lookup('hC789, "R7"); lookup('hE000, "R7");
    // R4 single 32K bank
    reg_write(16'h5100, 8'h00); reg_write(16'h5117, 8'h0C);
    lookup('h8000, "R4"); lookup('hA555, "R4"); lookup('hFFFF, "R4");
    // R5 two 16K banks
    reg_write(16'h5100, 8'h01); reg_write(16'h5115, 8'h06); reg_write(16'h5117, 8'h0B);
    lookup('h8001, "R5"); lookup('hBFFF, "R5"); lookup('hC002, "R5"); lookup('hE100, "R5");
    // R1 mode 2 through upper junk bits, R6 mixed layout
    reg_write(16'h5100, 8'hFE); reg_write(16'h5116, 8'h05); reg_write(16'h5117, 8'h83);
    lookup('h9000, "R6"); lookup('hB000, "R1"); lookup('hC010, "R6"); lookup('hE020, "R6");
    // R8 large bank folds back
    reg_write(16'h5100, 8'h03); reg_write(16'h5114, 8'h7F);
    lookup('h8ABC, "R8");
    // R11 neighbouring addresses ignored
    reg_write(16'h5112, 8'h44); reg_write(16'h5118, 8'h55);
    reg_write(16'h5101, 8'h00); reg_write(16'h50FF, 8'h11);
    lookup('h8ABC, "R11"); lookup('hFFFF, "R11"); lookup('h6000, "R11");
    // R12 back-to-back lookups
    @(negedge clk);
    lookup_valid = 1; lookup_addr = 16'hC000; expq.push_back(model('hC000)); tagq.push_back("R12");
    @(negedge clk);
    lookup_addr = 16'h7000; expq.push_back(model('h7000)); tagq.push_back("R12");
    @(negedge clk);
    lookup_valid = 0;
    repeat (4) @(negedge clk);
    if (expq.size() != 0) begin
      tests++; fails++; $display("FAIL R12 missing %0d results exp 0", expq.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule